// File: doc/BRIEF.md
# Product-Term Lending Chain

This block routes product terms between neighbouring logic cells. Each cell builds five AND terms from a shared literal vector. Each term picks its true and complemented literals through two masks, and a per-term use bit gates it. A cell can widen its OR by taking whole sets of five terms from the cells just below it in the same chain, up to three sets. That gives a widest sum of twenty terms. A cell that gives its set away drops out: its own output is zero.

Cells form independent chains of `GROUP` cells. By default there are sixteen cells split into two chains of eight. Terms only move upward inside a chain. The bottom cell of a chain can only give, and the top cell can only take. The block checks the borrow settings and raises an error flag in three cases:
- a chain's bottom cell asks to borrow;
- a request reaches below the chain's bottom cell;
- two cells claim the same lender.

An optional register stage, which is on by default, holds the sums and the flag.

Top module: `pexp_chain`

## Requirements
- R1: A product term is 1 when its use bit is 1 and every literal set in its true mask is 1 and every literal set in its complement mask is 0. Term t of the flat term bus uses mask bits t*NIN to t*NIN+NIN-1, and term t belongs to cell t/5. A term whose use bit is 0 is 0 whatever its masks. A used term with both masks empty is 1.
- R2: The 2-bit borrow field of cell c sits at bits 2c+1:2c. Its value n asks for the terms of cells c-1 down to c-n. The cell's sum is then the OR of its own five terms and those 5n terms.
- R3: A cell that any other cell borrows from outputs 0, even if it borrows itself.
- R4: Cells c and c' are in one chain when c/8 equals c'/8. No terms move between chains. A request that would reach past the chain's bottom cell takes only the cells that exist in the chain.
- R5: A nonzero borrow field on the bottom cell of a chain (c mod 8 = 0) sets the error flag.
- R6: A borrow field larger than the cell's position in its chain (c mod 8) sets the error flag.
- R7: Two cells whose requests include the same lender set the error flag. A valid, non-overlapping setting leaves the flag at 0.
- R8: With REG_OUT=1, the sums and the flag change one clock edge after the inputs change. While rst_n is low they read 0.
- R9: The top cell of a chain that borrows three sets ORs all twenty terms. Each of the twenty terms, when it is the only used and true one, drives that cell's sum to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| lit_in | input | NIN | Shared literal vector feeding every term |
| term_pos | input | NCELL*TERMS*NIN | True-literal select mask per term |
| term_neg | input | NCELL*TERMS*NIN | Complement-literal select mask per term |
| term_use | input | NCELL*TERMS | Per-term use bit; unused terms are forced to 0 |
| borrow_sets | input | NCELL*2 | Number of sets each cell takes from lower neighbours |
| cell_sum | output | NCELL | Per-cell OR result |
| cfg_err | output | 1 | Borrow configuration error flag |

## Verification
The bench sweeps every borrow setting of a chain against an arithmetic model. Both chains are driven at once with different settings, so a bug that lets one chain affect the other shows up as a wrong sum or flag.

The corner cases it targets each expose a specific fault:
- A design that keeps a lender's own terms alive gives a 1 where 0 is expected.
- A design that does not clamp requests at the chain edge pulls a neighbour chain's term into the sum.
- A design that misses overlapping claims leaves the flag low on a bad setting.
- An off-by-one in the set offsets loses one of the twenty terms of a three-set borrower, which the bench sees as a 0.

// File: rtl/pexp_chain.sv
module pexp_chain #(
  parameter int NCELL   = 16,
  parameter int GROUP   = 8,
  parameter int TERMS   = 5,
  parameter int MAXSETS = 3,
  parameter int NIN     = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SW     = $clog2(MAXSETS + 1),
  localparam int NTERM  = NCELL * TERMS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIN-1:0]       lit_in,
  input  logic [NTERM*NIN-1:0] term_pos,
  input  logic [NTERM*NIN-1:0] term_neg,
  input  logic [NTERM-1:0]     term_use,
  input  logic [NCELL*SW-1:0]  borrow_sets,
  output logic [NCELL-1:0]     cell_sum,
  output logic                 cfg_err
);

  logic [NTERM-1:0] pt;
  logic [NCELL-1:0] own, brw, lent, crowd, over, nxt_sum;
  logic [NCELL-1:0][MAXSETS:1] claim;
  logic nxt_err;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    assign pt[t] = term_use[t] &
                   (&((~term_pos[t*NIN +: NIN] | lit_in) &
                      (~term_neg[t*NIN +: NIN] | ~lit_in)));
  end

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    localparam int K = c % GROUP;
    wire [SW-1:0] req = borrow_sets[c*SW +: SW];
    assign own[c] = |pt[c*TERMS +: TERMS];
    if (K < MAXSETS) begin : g_chk
      assign over[c] = req > SW'(K);
    end else begin : g_nochk
      assign over[c] = 1'b0;
    end
    for (genvar d = 1; d <= MAXSETS; d++) begin : g_set
      if (d <= K) begin : g_in
        assign claim[c][d] = req >= SW'(d);
      end else begin : g_out
        assign claim[c][d] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCELL; c++) begin
      brw[c] = 1'b0;
      for (int d = 1; d <= MAXSETS; d++)
        if ((c % GROUP) >= d) brw[c] = brw[c] | (claim[c][d] & own[c-d]);
    end
  end

  always_comb begin
    for (int j = 0; j < NCELL; j++) begin
      int n;
      n = 0;
      for (int d = 1; d <= MAXSETS; d++)
        if ((j % GROUP) + d < GROUP) n = n + int'(claim[j+d][d]);
      lent[j]  = n != 0;
      crowd[j] = n > 1;
    end
  end

  assign nxt_sum = ~lent & (own | brw);
  assign nxt_err = (|over) | (|crowd);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_sum <= '0;
        cfg_err  <= 1'b0;
      end else begin
        cell_sum <= nxt_sum;
        cfg_err  <= nxt_err;
      end
    end
  end else begin : g_comb
    assign cell_sum = nxt_sum;
    assign cfg_err  = nxt_err;
  end

endmodule

// File: rtl/pexp_chain_chk.sv
module pexp_chain_chk #(
  parameter int NCELL   = 16,
  parameter int GROUP   = 8,
  parameter int MAXSETS = 3,
  parameter int SW      = 2,
  parameter bit LAT     = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCELL*SW-1:0] borrow_sets,
  input logic [NCELL-1:0]    cell_sum,
  input logic                cfg_err
);

  logic [NCELL*SW-1:0] bq;
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq     <= '0;
      primed <= 1'b0;
    end else begin
      bq     <= borrow_sets;
      primed <= 1'b1;
    end
  end

  wire [NCELL*SW-1:0] bs = LAT ? bq : borrow_sets;
  wire live = LAT ? primed : 1'b1;

  for (genvar c = 0; c < NCELL; c++) begin : g_c
    localparam int K = c % GROUP;
    if (K == 0) begin : g_low
      // R5
      low_cell_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bs[c*SW +: SW] != '0) |-> cfg_err);
    end
    if (K > 0 && K < MAXSETS) begin : g_cross
      // R6
      cross_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bs[c*SW +: SW] > SW'(K)) |-> cfg_err);
    end
    if (K < GROUP - 1) begin : g_lent
      // R3
      lent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bs[(c+1)*SW +: SW] != '0) |-> !cell_sum[c]);
    end
    if (K < GROUP - 2 && MAXSETS >= 2) begin : g_dbl
      // R7
      double_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bs[(c+1)*SW +: SW] != '0 && bs[(c+2)*SW +: SW] >= SW'(2)) |-> cfg_err);
    end
  end

endmodule

bind pexp_chain pexp_chain_chk #(
  .NCELL(NCELL), .GROUP(GROUP), .MAXSETS(MAXSETS), .SW(SW), .LAT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .borrow_sets(borrow_sets),
  .cell_sum(cell_sum), .cfg_err(cfg_err)
);

// File: tb/sim_pexp_chain.sv
module sim_pexp_chain;
  localparam int NC = 16, NI = 8, NT = NC * 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] lit_in = '0;
  logic [NT*NI-1:0] term_pos = '0, term_neg = '0;
  logic [NT-1:0] term_use = '0;
  logic [NC*2-1:0] borrow_sets = '0;
  logic [NC-1:0] cell_sum;
  logic cfg_err;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pexp_chain u0 (.clk(clk), .rst_n(rst_n), .lit_in(lit_in), .term_pos(term_pos),
    .term_neg(term_neg), .term_use(term_use), .borrow_sets(borrow_sets),
    .cell_sum(cell_sum), .cfg_err(cfg_err));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: own bit per cell, 2-bit borrow fields; returns {err, sums}
  function automatic logic [NC:0] model(input logic [NC*2-1:0] bs, input logic [NC-1:0] own);
    int hits [NC];
    logic [NC-1:0] got, s;
    logic e;
    e = 1'b0; got = '0;
    for (int j = 0; j < NC; j++) hits[j] = 0;
    for (int c = 0; c < NC; c++) begin
      int pos, want, take;
      pos = c % 8; want = int'(bs[2*c +: 2]);
      if (want > pos) e = 1'b1;
      take = (want > pos) ? pos : want;
      for (int d = 1; d <= take; d++) begin
        hits[c-d]++;
        got[c] = got[c] | own[c-d];
      end
    end
    for (int j = 0; j < NC; j++) begin
      if (hits[j] > 1) e = 1'b1;
      s[j] = (hits[j] == 0) ? (own[j] | got[j]) : 1'b0;
    end
    return {e, s};
  endfunction

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8 reset: drive a config that would produce ones
    for (int t = 0; t < NT; t++) term_use[t] = 1'b1;
    repeat (3) step();
    check(cell_sum == '0 && !cfg_err, "R8 reset clear", {cfg_err, cell_sum}, 0);
    rst_n = 1'b1;
    step();
    check(cell_sum == 16'hFFFF && !cfg_err, "R8 after reset", {cfg_err, cell_sum}, 32'hFFFF);
    // R8 latency: output holds until the next edge
    term_use = '0;
    #1;
    check(cell_sum == 16'hFFFF, "R8 one-edge latency hold", cell_sum, 32'hFFFF);
    step();
    check(cell_sum == '0, "R8 one-edge latency update / R1 unused terms", cell_sum, 0);

    // R1 literal selection on cell 1 (terms 5..9)
    term_pos[5*NI +: NI] = 8'b0000_0011;
    term_neg[5*NI +: NI] = 8'b0000_0100;
    term_use[5] = 1'b1;
    lit_in = 8'b0000_0011; step(); step();
    check(cell_sum[1] == 1'b1, "R1 literals match", cell_sum[1], 1);
    lit_in = 8'b0000_0111; step(); step();
    check(cell_sum[1] == 1'b0, "R1 complement literal blocks", cell_sum[1], 0);
    lit_in = 8'b0000_0001; step(); step();
    check(cell_sum[1] == 1'b0, "R1 missing true literal", cell_sum[1], 0);
    term_use[5] = 1'b0; term_use[6] = 1'b0; step(); step();
    check(cell_sum[1] == 1'b0, "R1 unused empty term forced 0", cell_sum[1], 0);
    term_use[7] = 1'b1; step(); step();
    check(cell_sum[1] == 1'b1, "R1 used empty term is 1", cell_sum[1], 1);
    term_use = '0; term_pos = '0; term_neg = '0;

    // R9 all twenty terms into top cell of chain 0
    borrow_sets = '0;
    borrow_sets[2*7 +: 2] = 2'd3;
    for (int j = 0; j < 20; j++) begin
      term_use = '0;
      term_use[20 + j] = 1'b1;
      step(); step();
      check(cell_sum[7:4] == 4'b1000 && !cfg_err, "R9 twenty-term OR", {cfg_err, cell_sum[7:4]}, 4'b1000);
    end
    term_use = '0; step(); step();
    check(cell_sum[7] == 1'b0, "R9 no used terms", cell_sum[7], 0);

    // R4 chain boundary: cell 9 asks for 3, may only take cell 8
    for (int c = 0; c < NC; c++) term_use[c*5] = 1'b1;
    borrow_sets = '0;
    borrow_sets[2*9 +: 2] = 2'd3;
    step(); step();
    check(cell_sum[7] == 1'b1 && cell_sum[8] == 1'b0 && cell_sum[9] == 1'b1,
          "R4 no crossing", cell_sum, 32'hFEFF);
    check(cfg_err == 1'b1, "R6 oversize request", cfg_err, 1);
    borrow_sets = '0;
    borrow_sets[2*8 +: 2] = 2'd1;
    step(); step();
    check(cfg_err == 1'b1 && cell_sum == 16'hFFFF, "R5 bottom cell request", {cfg_err, cell_sum}, 32'h1FFFF);
    borrow_sets = '0;
    borrow_sets[2*3 +: 2] = 2'd1;
    borrow_sets[2*4 +: 2] = 2'd2;
    step(); step();
    check(cfg_err == 1'b1, "R7 double claim", cfg_err, 1);
    check(cell_sum[2] == 1'b0 && cell_sum[3] == 1'b0, "R3 lent cells zero", cell_sum[3:2], 0);
    term_use = '0;

    // R2/R3/R4/R5/R6/R7 sweep: own[c] = lit_in[c%8] via one term per cell
    for (int c = 0; c < NC; c++) begin
      term_use[c*5 + (c % 5)] = 1'b1;
      term_pos[(c*5 + (c % 5))*NI + (c % 8)] = 1'b1;
    end
    for (int idx = 0; idx < 65536; idx++) begin
      logic [15:0] c0, c1;
      logic [7:0] lv;
      logic [NC:0] exp;
      c0 = 16'(idx); c1 = c0 ^ 16'h9C6B;
      lv = c0[7:0] ^ {c0[11:8], c0[15:12]} ^ 8'h5A;
      @(negedge clk);
      borrow_sets = {c1, c0};
      lit_in = lv;
      exp = model({c1, c0}, {lv, lv});
      @(negedge clk);
      check(cell_sum == exp[NC-1:0], "R2 R3 R4 sweep sums", cell_sum, exp[NC-1:0]);
      check(cfg_err == exp[NC], "R5 R6 R7 sweep error flag", cfg_err, exp[NC]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule